// File: doc/BRIEF.md
# New-Address Notification Queue

A switch reports every source address it learns as a short notification message. This block stores up to sixteen of those messages until the management processor collects them. Messages arrive on a valid/ready port from the receive dispatcher. The processor reads them through a fixed sixteen-word window starting at 0x800. A read of the first word of the window returns the oldest message and removes it from the queue. A read of any other word in the window returns a later message and leaves the queue unchanged.

Two interrupt cause bits record events. One is set when a message is stored. The other is set when a message arrives while the queue is full. Both bits are cleared by writing 1 to them, and a mask register selects which of them drive the active-low interrupt line. A control bit sets the policy for a full queue. The queue can hold the sender off through the ready signal, or it can keep ready high and discard the message.

Top module: `addr_notify_queue`

## Requirements
- R1: After reset the entry count is 0, the cause, mask and control registers read 0, `irq_n` is 1 and `in_ready` is 1.
- R2: A message is stored in a cycle where `in_valid` is high and the queue accepts it. A processor read of address 0x800 returns the stored messages oldest first, removes one each time, and lowers the count by one.
- R3: A read of address 0x800+k, with k from 1 to 15, returns the k-th message after the oldest if the queue holds more than k messages, and 0 otherwise. This read does not change the queue.
- R4: A read of 0x800 on an empty queue returns 0 and leaves the count at 0.
- R5: With control bit 0 at 0 (back-pressure policy), `in_ready` is 0 while the queue holds 16 messages and no pop occurs in that cycle. A held message is not lost.
- R6: With control bit 0 at 1 (discard policy), `in_ready` stays 1. A message that arrives while the queue is full and no pop occurs is discarded, and the queue contents are unchanged.
- R7: Cause bit 0 (register 0x810) is set by each stored message. Writing 1 to a bit at 0x810 clears it. A new set in the same cycle as a clear wins over the clear.
- R8: Cause bit 1 is set when `in_valid` is high, the queue is full and no pop occurs in the same cycle.
- R9: When the queue is full and a push and a pop happen in the same cycle, the message is accepted, the count stays at 16, and cause bit 1 is not set.
- R10: `irq_n` is 0 exactly when some cause bit is set whose matching bit in the mask register (0x814, bits 1:0) is 1.
- R11: The status register at 0x81C reports the current count, from 0 to 16. Control bit 0 is at 0x818.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Notification message offered |
| in_data | input | DATA_W | Notification message contents |
| in_ready | output | 1 | Queue can take the message this cycle |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | ADDR_W | Processor byte/word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, same cycle as the read |
| irq_n | output | 1 | Combined masked interrupt, active low |

## Verification
The checker tests the following on every cycle:
- the count moves by pushes minus pops and never exceeds 16;
- each push sets the arrival cause;
- an offer into a full queue with no pop sets the overflow cause;
- in discard mode `in_ready` stays high;
- a full-queue swap keeps the count at 16;
- an empty head read returns zero.

The following can only be shown by the bench scenarios:
- message ordering;
- peek offsets beyond the fill level;
- that discarded messages never show up later;
- that set wins over clear in the cause register;
- mask gating of the interrupt line.

// File: rtl/naq_pkg.sv
package naq_pkg;
  // Register word offsets relative to the register base.
  typedef enum logic [3:0] {
    RO_CAUSE = 4'h0,
    RO_MASK  = 4'h4,
    RO_CTRL  = 4'h8,
    RO_LEVEL = 4'hC
  } reg_ofs_e;

  localparam int CAUSE_NEW = 0;
  localparam int CAUSE_OVF = 1;
  localparam int NCAUSE    = 2;

  // Physical slot holding the entry 'off' positions after 'head'.
  function automatic int unsigned ring_slot(int unsigned head, int unsigned off,
                                            int unsigned depth);
    return (head + off) % depth;
  endfunction

  // Whether an offered message can be taken this cycle.
  function automatic logic can_take(logic full, logic popping);
    return !full || popping;
  endfunction
endpackage

// File: rtl/naq_store.sv
module naq_store
  import naq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  peek_off,
  output logic [DATA_W-1:0] peek_data,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  tail_idx;
  logic [IDX_W-1:0]  peek_idx;

  assign tail_idx = IDX_W'(ring_slot(32'(head_q), 32'(cnt_q), DEPTH));
  assign peek_idx = IDX_W'(ring_slot(32'(head_q), 32'(peek_off), DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem_q[tail_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) head_q <= IDX_W'(ring_slot(32'(head_q), 1, DEPTH));
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign peek_data = (CNT_W'(peek_off) < cnt_q) ? mem_q[peek_idx] : '0;
  assign count     = cnt_q;
endmodule

// File: rtl/naq_cause.sv
module naq_cause #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_vec,
  input  logic [NBITS-1:0] clr_vec,
  input  logic [NBITS-1:0] mask,
  output logic [NBITS-1:0] cause,
  output logic             irq_n
);
  logic [NBITS-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~clr_vec) | set_vec;
  end

  assign cause = cause_q;
  assign irq_n = ~|(cause_q & mask);
endmodule

// File: rtl/addr_notify_queue.sv
module addr_notify_queue
  import naq_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              DEPTH    = 16,
  parameter int              ADDR_W   = 12,
  parameter logic [11:0]     WIN_BASE = 12'h800,
  parameter logic [11:0]     REG_BASE = 12'h810
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_n
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(REG_BASE) + ADDR_W'(RO_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(REG_BASE) + ADDR_W'(RO_MASK);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_BASE) + ADDR_W'(RO_CTRL);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(REG_BASE) + ADDR_W'(RO_LEVEL);

  // Named internal events (observed by the bound checker).
  logic              in_win;
  logic [IDX_W-1:0]  peek_off;
  logic [DATA_W-1:0] peek_data;
  logic [CNT_W-1:0]  count_q;
  logic              full;
  logic              pop;
  logic              push;
  logic              ovf_evt;
  logic              drop_mode;
  logic [NCAUSE-1:0] cause_q;
  logic [NCAUSE-1:0] mask_q;
  logic [NCAUSE-1:0] set_vec;
  logic [NCAUSE-1:0] clr_vec;

  assign in_win   = cpu_addr[ADDR_W-1:IDX_W] == A_WIN[ADDR_W-1:IDX_W];
  assign peek_off = cpu_addr[IDX_W-1:0];
  assign full     = count_q == CNT_W'(DEPTH);
  assign pop      = cpu_rd && in_win && (peek_off == '0) && (count_q != '0);
  assign push     = in_valid && can_take(full, pop);
  assign ovf_evt  = in_valid && full && !pop;
  assign in_ready = drop_mode ? 1'b1 : can_take(full, pop);

  always_comb begin
    set_vec = '0;
    set_vec[CAUSE_NEW] = push;
    set_vec[CAUSE_OVF] = ovf_evt;
  end
  assign clr_vec = (cpu_wr && cpu_addr == A_CAUSE) ? cpu_wdata[NCAUSE-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      drop_mode <= 1'b0;
    end else if (cpu_wr) begin
      if (cpu_addr == A_MASK) mask_q    <= cpu_wdata[NCAUSE-1:0];
      if (cpu_addr == A_CTRL) drop_mode <= cpu_wdata[0];
    end
  end

  naq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(in_data),
    .peek_off(peek_off), .peek_data(peek_data), .count(count_q)
  );

  naq_cause #(.NBITS(NCAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask(mask_q), .cause(cause_q), .irq_n(irq_n)
  );

  always_comb begin
    cpu_rdata = '0;
    if (in_win)                    cpu_rdata = peek_data;
    else if (cpu_addr == A_CAUSE)  cpu_rdata = DATA_W'(cause_q);
    else if (cpu_addr == A_MASK)   cpu_rdata = DATA_W'(mask_q);
    else if (cpu_addr == A_CTRL)   cpu_rdata = DATA_W'(drop_mode);
    else if (cpu_addr == A_LEVEL)  cpu_rdata = DATA_W'(count_q);
  end
endmodule

// File: rtl/naq_checker.sv
module naq_checker #(
  parameter int          DATA_W   = 32,
  parameter int          DEPTH    = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] WIN_BASE = 12'h800,
  localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              push,
  input logic              pop,
  input logic              full,
  input logic              drop_mode,
  input logic [CNT_W-1:0]  count_q,
  input logic [1:0]        cause_q,
  input logic              cpu_rd,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop) |=> count_q == $past(count_q) + CNT_W'($past(push)) - CNT_W'($past(pop))); // R2
  AST_NEW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> cause_q[0]); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !pop) |=> cause_q[1]); // R8
  AST_DROP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_mode |-> in_ready); // R6
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> count_q == CNT_W'(DEPTH)); // R9
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == ADDR_W'(WIN_BASE) && count_q == '0) |-> cpu_rdata == '0); // R4
endmodule

bind addr_notify_queue naq_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
) u_naq_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .push(push), .pop(pop), .full(full), .drop_mode(drop_mode),
  .count_q(count_q), .cause_q(cause_q), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata)
);

// File: tb/addr_notify_queue_bench.sv
module addr_notify_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [$];
  bit drop_pol = 0;

  always #5 clk = ~clk;

  addr_notify_queue u_addr_notify_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1 cpu_rd = 1; cpu_addr = a;
    @(negedge clk);
    check(cpu_rdata === exp, req, cpu_rdata, exp);
    @(posedge clk); #1 cpu_rd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1 cpu_wr = 0;
  endtask

  // Driver: offers a message, predicts acceptance and feeds the scoreboard.
  task automatic offer(input logic [31:0] d, input string req);
    logic exp_rdy;
    @(posedge clk); #1 in_valid = 1; in_data = d;
    @(negedge clk);
    exp_rdy = drop_pol ? 1'b1 : (model.size() < 16);
    check(in_ready === exp_rdy, req, 32'(in_ready), 32'(exp_rdy));
    if (model.size() < 16) model.push_back(d);
    @(posedge clk); #1 in_valid = 0;
  endtask

  // Monitor: pops the head and compares against the scoreboard.
  task automatic pop_chk(input string req);
    logic [31:0] e;
    e = (model.size() != 0) ? model.pop_front() : 32'h0;
    rd_chk(12'h800, e, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(irq_n === 1'b1, "R1 irq_n", 32'(irq_n), 32'h1);
    check(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);
    rd_chk(12'h81C, 0, "R1 level");
    rd_chk(12'h810, 0, "R1 cause");
    rd_chk(12'h814, 0, "R1 mask");
    rd_chk(12'h818, 0, "R1 ctrl");

    rd_chk(12'h800, 0, "R4 empty head");
    rd_chk(12'h81C, 0, "R4 level after empty read");

    for (int i = 0; i < 3; i++) offer(32'hA000_0000 + 32'(i), "R2 accept");
    rd_chk(12'h810, 1, "R7 arrival cause");
    @(negedge clk);
    check(irq_n === 1'b1, "R10 masked", 32'(irq_n), 32'h1);
    wr(12'h814, 1);
    @(negedge clk);
    check(irq_n === 1'b0, "R10 unmasked", 32'(irq_n), 32'h0);
    rd_chk(12'h801, model[1], "R3 peek 1");
    rd_chk(12'h802, model[2], "R3 peek 2");
    rd_chk(12'h803, 0, "R3 peek beyond fill");
    rd_chk(12'h81C, 3, "R11 level 3");
    pop_chk("R2 oldest first");
    rd_chk(12'h81C, 2, "R2 level after pop");
    wr(12'h810, 1);
    rd_chk(12'h810, 0, "R7 w1c");
    @(negedge clk);
    check(irq_n === 1'b1, "R10 cleared", 32'(irq_n), 32'h1);

    for (int i = 0; i < 14; i++) offer(32'hB000_0000 + 32'(i), "R2 fill");
    rd_chk(12'h81C, 16, "R11 level full");
    wr(12'h810, 3);
    offer(32'hDEAD_0001, "R5 stall");
    rd_chk(12'h810, 2, "R8 overflow cause");
    rd_chk(12'h81C, 16, "R5 level held");

    // Full queue, push and pop together.
    wr(12'h810, 3);
    @(posedge clk); #1 in_valid = 1; in_data = 32'hC0DE_0009; cpu_rd = 1; cpu_addr = 12'h800;
    @(negedge clk);
    check(in_ready === 1'b1, "R9 ready on swap", 32'(in_ready), 32'h1);
    check(cpu_rdata === model[0], "R9 head on swap", cpu_rdata, model[0]);
    void'(model.pop_front());
    model.push_back(32'hC0DE_0009);
    @(posedge clk); #1 in_valid = 0; cpu_rd = 0;
    rd_chk(12'h81C, 16, "R9 level stays");
    rd_chk(12'h810, 1, "R9 no overflow");

    wr(12'h818, 1); drop_pol = 1;
    rd_chk(12'h818, 1, "R11 ctrl readback");
    wr(12'h810, 3);
    offer(32'hDEAD_0002, "R6 ready in drop");
    rd_chk(12'h810, 2, "R8 overflow in drop");
    rd_chk(12'h81C, 16, "R6 level unchanged");
    for (int i = 0; i < 16; i++) pop_chk("R6 contents intact");
    rd_chk(12'h81C, 0, "R2 drained");

    // Set wins over clear.
    wr(12'h810, 3);
    @(posedge clk); #1 in_valid = 1; in_data = 32'h5E7_0001;
    cpu_wr = 1; cpu_addr = 12'h810; cpu_wdata = 1;
    model.push_back(32'h5E7_0001);
    @(posedge clk); #1 in_valid = 0; cpu_wr = 0;
    rd_chk(12'h810, 1, "R7 set beats clear");
    pop_chk("R2 last entry");
    rd_chk(12'h800, 0, "R4 empty again");

    done = 1;
    summary();
  end
endmodule